// File: doc/BRIEF.md
# Frame-Counting Receive FIFO

This block is a byte FIFO for one receive channel fed from a time-slot interface that has no flow control. Every byte offered on the write port is stored, whatever the fill state; there is no full flag and no stall. A write may carry an end-of-frame marker, and each marked write adds one to a frame count. The host pops bytes one at a time through a show-ahead read port and, after taking a whole frame, pulses a frame-done strobe that removes that frame from the count.

Both the byte pointers and the frame pointers are plain modular counters. When more bytes arrive than the storage holds, new bytes overwrite the oldest ones and the byte level wraps. When more frames are stored than the frame counter can express, the count wraps. Nothing flags either case. The host detects an overflow afterwards: the frame count reads lower than on its previous reading although no frame was done in between. It then clears the FIFO with a synchronous software reset.

Top module: `rx_frame_fifo`

## Requirements
- R1: After `rst_n` low or `fifo_reset` high at a clock edge, `empty` is 1 and both `byte_level` and `frame_count` are 0.
- R2: Bytes leave in the order they were written. `rd_data` always shows the oldest unread byte. A byte written into an otherwise empty FIFO is visible on `rd_data` right after the write edge.
- R3: `byte_level` equals accepted writes minus accepted reads, modulo 2^ADDR_W (64 by default). It updates at the edge that accepts the access.
- R4: A write with `wr_eof`=1 raises `frame_count` by 1. An accepted `frame_done` lowers it by 1. When both occur in one cycle, the count is unchanged.
- R5: Writes are never refused. With FCNT_W=5, the 31st stored frame reads as 31 and the 32nd wraps the count to 0.
- R6: Writing 2^ADDR_W+1 bytes with no reads leaves `byte_level` at 1. `rd_data` then shows the last byte written, which has overwritten the oldest slot.
- R7: `rd_en` is ignored while the read and write byte pointers are equal. `frame_done` is ignored while `frame_count` is 0.
- R8: `empty` is 1 exactly when `byte_level` is 0 and `frame_count` is 0.
- R9: `fifo_reset` takes priority over a write, read or frame-done in the same cycle: the result is the R1 state.
- R10: `wr_eof` with `wr_en`=0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_reset | input | 1 | Synchronous software clear of pointers and counters |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_data | input | DATA_W | Incoming byte |
| wr_eof | input | 1 | Byte ends a frame (qualified by `wr_en`) |
| rd_en | input | 1 | Pop the byte shown on `rd_data` |
| frame_done | input | 1 | Host has consumed one whole frame |
| rd_data | output | DATA_W | Oldest unread byte (show-ahead) |
| byte_level | output | ADDR_W | Unread byte count, modulo depth |
| frame_count | output | FCNT_W | Stored frame count, modulo 2^FCNT_W |
| empty | output | 1 | No bytes and no frames pending |

## Verification
Every output comes straight from registered pointers or from the storage array through combinational logic. Each result is therefore due one clock edge after the input that causes it. The bench drives inputs on the falling edge, lets one rising edge pass, and samples all outputs on the next falling edge. This holds for the table-driven steps and for the directed reset, wrap and overflow sequences, so every check reads the state left by exactly one edge.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int FCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_reset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              rd_en,
  input  logic              frame_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] byte_level,
  output logic [FCNT_W-1:0] frame_count,
  output logic              empty
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [FCNT_W-1:0] fin_ptr, fout_ptr;

  logic clear, bytes_held, frames_held, rd_ok, fd_ok, fin_inc;

  assign clear       = !rst_n || fifo_reset;
  assign bytes_held  = wr_ptr != rd_ptr;
  assign frames_held = fin_ptr != fout_ptr;
  assign rd_ok       = rd_en && bytes_held;
  assign fd_ok       = frame_done && frames_held;
  assign fin_inc     = wr_en && wr_eof;

  assign rd_data     = mem[rd_ptr];
  assign byte_level  = wr_ptr - rd_ptr;
  assign frame_count = fin_ptr - fout_ptr;
  assign empty       = !bytes_held && !frames_held;

  always_ff @(posedge clk) begin
    if (wr_en && !clear) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fin_ptr  <= '0;
      fout_ptr <= '0;
    end else begin
      if (wr_en)   wr_ptr   <= wr_ptr + 1'b1;
      if (rd_ok)   rd_ptr   <= rd_ptr + 1'b1;
      if (fin_inc) fin_ptr  <= fin_ptr + 1'b1;
      if (fd_ok)   fout_ptr <= fout_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int FCNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_reset,
  input logic              wr_en,
  input logic              wr_eof,
  input logic              rd_en,
  input logic              frame_done,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] byte_level,
  input logic [FCNT_W-1:0] frame_count,
  input logic              empty
);

  // R1 R9
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (empty && byte_level == '0 && frame_count == '0));

  // R4
  frame_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_reset && wr_en && wr_eof && !frame_done)
      |=> frame_count == FCNT_W'($past(frame_count) + 1'b1));

  // R7
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_reset && frame_done && frame_count == '0 && !wr_en)
      |=> frame_count == '0);

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_reset && !wr_en && !rd_en) |=> $stable(byte_level));

  // R3
  write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_reset && wr_en && !rd_en)
      |=> byte_level == ADDR_W'($past(byte_level) + 1'b1));

  // R8
  empty_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (byte_level == '0 && frame_count == '0));

endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_reset(fifo_reset), .wr_en(wr_en),
  .wr_eof(wr_eof), .rd_en(rd_en), .frame_done(frame_done),
  .rd_data(rd_data), .byte_level(byte_level), .frame_count(frame_count),
  .empty(empty)
);

// File: tb/rx_frame_fifo_tb.sv
module rx_frame_fifo_tb;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int FCNT_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst_n, fifo_reset, wr_en, wr_eof, rd_en, frame_done;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [ADDR_W-1:0] byte_level;
  logic [FCNT_W-1:0] frame_count;
  logic empty;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_frame_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_reset(fifo_reset), .wr_en(wr_en),
    .wr_data(wr_data), .wr_eof(wr_eof), .rd_en(rd_en),
    .frame_done(frame_done), .rd_data(rd_data), .byte_level(byte_level),
    .frame_count(frame_count), .empty(empty)
  );

  // {wr_en, wr_eof, wr_data, rd_en, frame_done, chk_rd, exp_level, exp_fcnt, exp_empty, exp_rd}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b1, 6'd1, 5'd0, 1'b0, 8'hA1}, // R2 R3
    {1'b1, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b1, 6'd2, 5'd1, 1'b0, 8'hA1}, // R4
    {1'b1, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b1, 6'd3, 5'd1, 1'b0, 8'hA1}, // R3
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 6'd2, 5'd1, 1'b0, 8'hB2}, // R2
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 6'd1, 5'd0, 1'b0, 8'hC3}, // R4 R8
    {1'b1, 1'b1, 8'hD4, 1'b1, 1'b0, 1'b1, 6'd1, 5'd1, 1'b0, 8'hD4}, // R3 R4
    {1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 1'b1, 6'd1, 5'd1, 1'b0, 8'hD4}, // R10
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 6'd0, 5'd0, 1'b1, 8'h00}, // R8
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 6'd0, 5'd0, 1'b1, 8'h00}, // R7
    {1'b1, 1'b1, 8'hE5, 1'b0, 1'b1, 1'b1, 6'd1, 5'd1, 1'b0, 8'hE5}, // R7
    {1'b1, 1'b1, 8'h66, 1'b0, 1'b1, 1'b1, 6'd2, 5'd1, 1'b0, 8'hE5}, // R4
    {1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 6'd2, 5'd1, 1'b0, 8'hE5}  // R10
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fifo_reset = 1'b0; wr_en = 1'b0; wr_eof = 1'b0; wr_data = '0;
    rd_en = 1'b0; frame_done = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string req, input int lvl, input int fc, input int emp);
    chk({req, " byte_level"}, int'(byte_level), lvl);
    chk({req, " frame_count"}, int'(frame_count), fc);
    chk({req, " empty"}, int'(empty), emp);
  endtask

  task automatic soft_clear();
    idle_inputs();
    fifo_reset = 1'b1;
    tick();
    fifo_reset = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    check_state("R1 reset", 0, 0, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [32:0] v;
      v = VEC[i];
      wr_en = v[32]; wr_eof = v[31]; wr_data = v[30:23];
      rd_en = v[22]; frame_done = v[21];
      tick();
      check_state($sformatf("R3/R4/R8 vec%0d", i), int'(v[19:14]), int'(v[13:9]), int'(v[8]));
      if (v[20]) chk($sformatf("R2 vec%0d rd_data", i), int'(rd_data), int'(v[7:0]));
    end
    idle_inputs();

    soft_clear();
    check_state("R1 soft clear", 0, 0, 1);

    // R5 frame counter wrap
    for (int f = 1; f <= 32; f++) begin
      wr_en = 1'b1; wr_eof = 1'b1; wr_data = 8'(f);
      tick();
      if (f == 31) chk("R5 count at 31 frames", int'(frame_count), 31);
    end
    idle_inputs();
    chk("R5 count wrapped", int'(frame_count), 0);
    chk("R5 level after 32 bytes", int'(byte_level), 32);
    chk("R5 not empty", int'(empty), 0);
    chk("R2 oldest byte", int'(rd_data), 1);

    // R9 reset beats same-cycle activity
    wr_en = 1'b1; wr_eof = 1'b1; wr_data = 8'h5A; rd_en = 1'b1; frame_done = 1'b1;
    fifo_reset = 1'b1;
    tick();
    idle_inputs();
    check_state("R9 clear priority", 0, 0, 1);

    // R6 byte overflow
    for (int b = 0; b <= DEPTH; b++) begin
      wr_en = 1'b1; wr_data = 8'(b + 8'h10);
      tick();
    end
    idle_inputs();
    chk("R6 level wrapped", int'(byte_level), 1);
    chk("R6 overwritten slot", int'(rd_data), (DEPTH + 16) & 8'hFF);
    chk("R6 frames none", int'(frame_count), 0);

    // R7 read with equal pointers ignored (overflowed to exactly DEPTH bytes)
    soft_clear();
    for (int b = 0; b < DEPTH; b++) begin
      wr_en = 1'b1; wr_data = 8'(b);
      tick();
    end
    idle_inputs();
    rd_en = 1'b1;
    tick();
    idle_inputs();
    chk("R7 rd ignored level", int'(byte_level), 0);
    chk("R7 rd ignored data", int'(rd_data), 0);

    // R1 hardware reset mid-run
    wr_en = 1'b1; wr_eof = 1'b1; wr_data = 8'h11;
    tick();
    idle_inputs();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    check_state("R1 rst_n", 0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule